// File: doc/BRIEF.md
# Isochronous Complete-Split Response Handler

This block decides how one periodic isochronous IN split descriptor changes after a complete-split is answered by the transaction translator. When `evalValid` is high, the block samples the translator's answer, the number of bytes received, the descriptor's current fields and the index of the current microframe. One clock later it presents the rewritten descriptor fields: active flag, status bits, remaining byte count and progress mask. It can also raise a request to repeat the complete-split at once, or a pulse saying the transaction was abandoned.

The block keeps its own count of consecutive error retries, because the descriptor has no room for one. The schedule walker feeds descriptors in and writes the updated fields back. Packet encoding, memory access and start-split issue live elsewhere.

Top module: `csplit_resp_handler`

## Requirements
- R1: Response codes on `respCode` are 0 = DATA0, 1 = DATA1, 2 = MDATA, 3 = NYET and 4 = transaction error. Codes 5 to 7 change nothing. The status bits are bit 0 = transaction error and bit 1 = missed microframe. The result of a sample taken with `evalValid` high appears on the outputs one clock later, with `updValid` high for that one cycle. A sampled status bit that is already set is never cleared.
- R2: A transaction error sets status bit 0 and leaves the byte count and progress mask unchanged. While fewer than `MAX_RETRY` (2) retries have been used in a row, it raises `retryReq` and keeps the descriptor active.
- R3: The third consecutive transaction error finds the retries used up. It clears the active flag, pulses `uframeAbort` and does not raise `retryReq`.
- R4: A transaction error sampled while `uframeEnd` is high clears the active flag, pulses `uframeAbort` and does not raise `retryReq`, even if retries remain.
- R5: Any sampled response other than an error returns the retry count to zero, so a later error is retried again.
- R6: DATA0 or DATA1 subtracts the received bytes from the byte count, stopping at zero. It also clears the active flag and sets the progress-mask bit of the current microframe.
- R7: A DATA response that leaves the byte count nonzero (a short packet) sets no status bit.
- R8: The complete-split is the last one when the C-mask XOR the updated progress mask is zero. NYET on a split that is not the last only sets the current progress bit; the descriptor stays active.
- R9: NYET on the last split sets the current progress bit, clears the active flag, sets no status bit and leaves the byte count unchanged.
- R10: MDATA on a split that is not the last subtracts the received bytes, sets the current progress bit and keeps the descriptor active.
- R11: MDATA on the last split sets status bit 0 and clears the active flag, leaving the byte count unchanged.
- R12: The window check requires the C-mask bit at `uframeIdx` to be set. The progress check requires every C-mask bit below `uframeIdx` to match the progress mask. If the window check passes but the progress check fails, the block sets status bit 1, clears the active flag and leaves the progress mask and byte count unchanged.
- R13: An inactive descriptor, or one whose C-mask bit at `uframeIdx` is clear, is echoed unchanged, with no retry and no abort.
- R14: After reset, `updValid`, `retryReq` and `uframeAbort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | Sample the response and the descriptor this cycle |
| respCode | input | 3 | Translator response code |
| rxBytes | input | BYTE_W | Payload bytes received |
| uframeIdx | input | IDX_W | Current microframe index |
| uframeEnd | input | 1 | Microframe is ending |
| descActive | input | 1 | Descriptor active flag |
| descStatus | input | 2 | Descriptor status bits |
| descBytes | input | BYTE_W | Remaining byte count |
| cMask | input | MASK_W | Complete-split schedule mask |
| cProgMask | input | MASK_W | Complete-split progress mask |
| updValid | output | 1 | Updated fields valid |
| updActive | output | 1 | Updated active flag |
| updStatus | output | 2 | Updated status bits |
| updBytes | output | BYTE_W | Updated byte count |
| updProgMask | output | MASK_W | Updated progress mask |
| retryReq | output | 1 | Repeat the complete-split now |
| uframeAbort | output | 1 | Transaction abandoned after errors |

## Verification
Each response code is applied both on a complete-split that is not the last and on the final one. The resulting pairs differ only in the last-split decision, so they show whether that decision is taken from the updated progress mask. Full, short and oversized DATA payloads separate the saturating subtraction from the short-packet rule. A gap in the progress mask and a C-mask bit that is clear at the current index separate the missed-microframe outcome from a plain echo. Runs of errors interrupted by a NYET, or by the microframe ending, show whether the retry count resets and where the retries run out.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
  typedef enum logic [2:0] {
    RESP_DATA0 = 3'd0,
    RESP_DATA1 = 3'd1,
    RESP_MDATA = 3'd2,
    RESP_NYET  = 3'd3,
    RESP_XERR  = 3'd4
  } resp_e;

  localparam int ST_XACT = 0;
  localparam int ST_MISS = 1;

  typedef struct packed {
    logic load;
    logic clrActive;
    logic setXact;
    logic setMissed;
    logic advBytes;
    logic markProg;
    logic retry;
    logic abort;
  } strobe_t;
endpackage

// File: rtl/csplit_ctrl.sv
module csplit_ctrl
  import csplit_pkg::*;
#(
  parameter int MAX_RETRY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evalValid,
  input  logic [2:0] respCode,
  input  logic       uframeEnd,
  input  logic       descActive,
  input  logic       inWindow,
  input  logic       inOrder,
  input  logic       lastSplit,
  output strobe_t    strobe
);
  localparam int CNT_W = $clog2(MAX_RETRY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RETRY);

  logic [CNT_W-1:0] retryCnt, retryCntNext;
  resp_e resp;

  assign resp = resp_e'(respCode);

  always_comb begin
    strobe       = '0;
    strobe.load  = evalValid;
    retryCntNext = retryCnt;
    if (evalValid && descActive && inWindow) begin
      if (!inOrder) begin
        strobe.setMissed = 1'b1;
        strobe.clrActive = 1'b1;
        retryCntNext     = '0;
      end else begin
        case (resp)
          RESP_XERR: begin
            strobe.setXact = 1'b1;
            if (uframeEnd || retryCnt >= CNT_MAX) begin
              strobe.clrActive = 1'b1;
              strobe.abort     = 1'b1;
              retryCntNext     = '0;
            end else begin
              strobe.retry = 1'b1;
              retryCntNext = retryCnt + 1'b1;
            end
          end
          RESP_DATA0, RESP_DATA1: begin
            strobe.advBytes  = 1'b1;
            strobe.markProg  = 1'b1;
            strobe.clrActive = 1'b1;
            retryCntNext     = '0;
          end
          RESP_NYET: begin
            strobe.markProg  = 1'b1;
            strobe.clrActive = lastSplit;
            retryCntNext     = '0;
          end
          RESP_MDATA: begin
            strobe.markProg  = 1'b1;
            strobe.setXact   = lastSplit;
            strobe.clrActive = lastSplit;
            strobe.advBytes  = !lastSplit;
            retryCntNext     = '0;
          end
          default: retryCntNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) retryCnt <= '0;
    else        retryCnt <= retryCntNext;
  end
endmodule

// File: rtl/csplit_dp.sv
module csplit_dp
  import csplit_pkg::*;
#(
  parameter int MASK_W = 8,
  parameter int BYTE_W = 10,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [BYTE_W-1:0] rxBytes,
  input  logic [IDX_W-1:0]  uframeIdx,
  input  logic              descActive,
  input  logic [1:0]        descStatus,
  input  logic [BYTE_W-1:0] descBytes,
  input  logic [MASK_W-1:0] cMask,
  input  logic [MASK_W-1:0] cProgMask,
  output logic              inWindow,
  output logic              inOrder,
  output logic              lastSplit,
  output logic              updValid,
  output logic              updActive,
  output logic [1:0]        updStatus,
  output logic [BYTE_W-1:0] updBytes,
  output logic [MASK_W-1:0] updProgMask,
  output logic              retryReq,
  output logic              uframeAbort
);
  logic [MASK_W-1:0] curBit, belowMask, progNext;
  logic [BYTE_W-1:0] bytesLeft;
  logic [1:0]        statusSet;

  assign curBit    = MASK_W'(1) << uframeIdx;
  assign belowMask = curBit - MASK_W'(1);
  assign progNext  = cProgMask | curBit;

  assign inWindow  = |(cMask & curBit);
  assign inOrder   = ((cMask ^ cProgMask) & belowMask) == '0;
  assign lastSplit = (cMask ^ progNext) == '0;

  assign bytesLeft = (descBytes >= rxBytes) ? descBytes - rxBytes : '0;

  always_comb begin
    statusSet          = descStatus;
    statusSet[ST_XACT] = descStatus[ST_XACT] | strobe.setXact;
    statusSet[ST_MISS] = descStatus[ST_MISS] | strobe.setMissed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      updValid    <= 1'b0;
      updActive   <= 1'b0;
      updStatus   <= '0;
      updBytes    <= '0;
      updProgMask <= '0;
      retryReq    <= 1'b0;
      uframeAbort <= 1'b0;
    end else begin
      updValid    <= strobe.load;
      retryReq    <= strobe.load & strobe.retry;
      uframeAbort <= strobe.load & strobe.abort;
      if (strobe.load) begin
        updActive   <= descActive & ~strobe.clrActive;
        updStatus   <= statusSet;
        updBytes    <= strobe.advBytes ? bytesLeft : descBytes;
        updProgMask <= strobe.markProg ? progNext : cProgMask;
      end
    end
  end
endmodule

// File: rtl/csplit_resp_handler.sv
module csplit_resp_handler
  import csplit_pkg::*;
#(
  parameter int MASK_W    = 8,
  parameter int BYTE_W    = 10,
  parameter int MAX_RETRY = 2,
  localparam int IDX_W    = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evalValid,
  input  logic [2:0]        respCode,
  input  logic [BYTE_W-1:0] rxBytes,
  input  logic [IDX_W-1:0]  uframeIdx,
  input  logic              uframeEnd,
  input  logic              descActive,
  input  logic [1:0]        descStatus,
  input  logic [BYTE_W-1:0] descBytes,
  input  logic [MASK_W-1:0] cMask,
  input  logic [MASK_W-1:0] cProgMask,
  output logic              updValid,
  output logic              updActive,
  output logic [1:0]        updStatus,
  output logic [BYTE_W-1:0] updBytes,
  output logic [MASK_W-1:0] updProgMask,
  output logic              retryReq,
  output logic              uframeAbort
);
  strobe_t strobe;
  logic    inWindow, inOrder, lastSplit;

  csplit_ctrl #(.MAX_RETRY(MAX_RETRY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evalValid(evalValid), .respCode(respCode),
    .uframeEnd(uframeEnd), .descActive(descActive), .inWindow(inWindow),
    .inOrder(inOrder), .lastSplit(lastSplit), .strobe(strobe)
  );

  csplit_dp #(.MASK_W(MASK_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxBytes(rxBytes),
    .uframeIdx(uframeIdx), .descActive(descActive), .descStatus(descStatus),
    .descBytes(descBytes), .cMask(cMask), .cProgMask(cProgMask),
    .inWindow(inWindow), .inOrder(inOrder), .lastSplit(lastSplit),
    .updValid(updValid), .updActive(updActive), .updStatus(updStatus),
    .updBytes(updBytes), .updProgMask(updProgMask), .retryReq(retryReq),
    .uframeAbort(uframeAbort)
  );
endmodule

// File: rtl/csplit_resp_checker.sv
module csplit_resp_checker #(
  parameter int MASK_W    = 8,
  parameter int BYTE_W    = 10,
  parameter int MAX_RETRY = 2,
  localparam int IDX_W    = $clog2(MASK_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evalValid,
  input logic [2:0]        respCode,
  input logic [BYTE_W-1:0] rxBytes,
  input logic [IDX_W-1:0]  uframeIdx,
  input logic              uframeEnd,
  input logic              descActive,
  input logic [1:0]        descStatus,
  input logic [BYTE_W-1:0] descBytes,
  input logic [MASK_W-1:0] cMask,
  input logic [MASK_W-1:0] cProgMask,
  input logic              updValid,
  input logic              updActive,
  input logic [1:0]        updStatus,
  input logic [BYTE_W-1:0] updBytes,
  input logic [MASK_W-1:0] updProgMask,
  input logic              retryReq,
  input logic              uframeAbort
);
  logic [7:0] consecRetry;

  always_ff @(posedge clk) begin
    if (!rst_n)        consecRetry <= '0;
    else if (updValid) consecRetry <= retryReq ? consecRetry + 8'd1 : 8'd0;
  end

  // R1: a result appears exactly one clock after a sample
  a_r1_valid_follows_eval: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid |=> updValid);

  // R1: a status bit that was sampled set stays set
  a_r1_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid |=> ((updStatus & $past(descStatus)) == $past(descStatus)));

  // R2: a retry request only ever answers a transaction error
  a_r2_retry_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid && respCode != 3'd4 |=> !retryReq);

  // R2: a retried descriptor stays active
  a_r2_retry_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    retryReq |-> updActive && updStatus[0]);

  // R3: consecutive retries never exceed the limit
  a_r3_retry_limit: assert property (@(posedge clk) disable iff (!rst_n)
    consecRetry <= 8'(MAX_RETRY));

  // R3, R4: abort and retry are exclusive and abort leaves it inactive
  a_r3_abort_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    uframeAbort |-> !updActive && !retryReq);

  // R4: an error at microframe end never asks for a retry
  a_r4_no_retry_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid && uframeEnd |=> !retryReq);

  // R13: an inactive descriptor comes back inactive with no side effects
  a_r13_inactive_echo: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid && !descActive |=> !updActive && !retryReq && !uframeAbort);

  // R8: the progress mask only gains bits
  a_r8_prog_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    evalValid |=> ((updProgMask & $past(cProgMask)) == $past(cProgMask)));
endmodule

bind csplit_resp_handler csplit_resp_checker #(
  .MASK_W(MASK_W), .BYTE_W(BYTE_W), .MAX_RETRY(MAX_RETRY)
) u_chk (.*);

// File: tb/csplit_resp_handler_tb.sv
module csplit_resp_handler_tb;
  localparam int MASK_W = 8;
  localparam int BYTE_W = 10;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evalValid = 1'b0;
  logic [2:0]        respCode = '0;
  logic [BYTE_W-1:0] rxBytes = '0;
  logic [IDX_W-1:0]  uframeIdx = '0;
  logic              uframeEnd = 1'b0;
  logic              descActive = 1'b0;
  logic [1:0]        descStatus = '0;
  logic [BYTE_W-1:0] descBytes = '0;
  logic [MASK_W-1:0] cMask = '0;
  logic [MASK_W-1:0] cProgMask = '0;
  logic              updValid, updActive, retryReq, uframeAbort;
  logic [1:0]        updStatus;
  logic [BYTE_W-1:0] updBytes;
  logic [MASK_W-1:0] updProgMask;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  csplit_resp_handler u_dut (.*);

  typedef struct packed {
    logic [2:0]  resp;
    logic [9:0]  rx;
    logic        act;
    logic [1:0]  st;
    logic [9:0]  bytes;
    logic [7:0]  prog;
    logic [2:0]  idx;
    logic        eAct;
    logic [1:0]  eSt;
    logic [9:0]  eBytes;
    logic [7:0]  eProg;
  } vec_t;

  // C-mask is 8'h1C for every vector (indices 2, 3 and 4 scheduled)
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 10'd100, 1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0, 2'b00, 10'd0,   8'h04}, // R6 full DATA0
    '{3'd1, 10'd40,  1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0, 2'b00, 10'd60,  8'h04}, // R7 short DATA1
    '{3'd1, 10'd50,  1'b1, 2'b00, 10'd20,  8'h04, 3'd3, 1'b0, 2'b00, 10'd0,   8'h0C}, // R6 oversize saturates
    '{3'd3, 10'd0,   1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b1, 2'b00, 10'd100, 8'h04}, // R8 NYET not last
    '{3'd3, 10'd0,   1'b1, 2'b00, 10'd100, 8'h0C, 3'd4, 1'b0, 2'b00, 10'd100, 8'h1C}, // R9 NYET last
    '{3'd2, 10'd30,  1'b1, 2'b00, 10'd100, 8'h04, 3'd3, 1'b1, 2'b00, 10'd70,  8'h0C}, // R10 MDATA not last
    '{3'd2, 10'd30,  1'b1, 2'b00, 10'd100, 8'h0C, 3'd4, 1'b0, 2'b01, 10'd100, 8'h1C}, // R11 MDATA last
    '{3'd3, 10'd0,   1'b1, 2'b00, 10'd100, 8'h04, 3'd4, 1'b0, 2'b10, 10'd100, 8'h04}, // R12 missed uframe
    '{3'd0, 10'd10,  1'b0, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0, 2'b00, 10'd100, 8'h00}, // R13 inactive echo
    '{3'd0, 10'd10,  1'b1, 2'b00, 10'd100, 8'h00, 3'd6, 1'b1, 2'b00, 10'd100, 8'h00}, // R13 outside window
    '{3'd6, 10'd10,  1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b1, 2'b00, 10'd100, 8'h00}, // R1 unused code
    '{3'd3, 10'd0,   1'b1, 2'b01, 10'd100, 8'h00, 3'd2, 1'b1, 2'b01, 10'd100, 8'h04}  // R1 sticky status
  };

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one sample at a falling edge; outputs are read at the next falling edge
  task automatic apply(input logic [2:0] r, input logic [9:0] rx, input logic a,
                       input logic [1:0] st, input logic [9:0] b,
                       input logic [7:0] pm, input logic [2:0] ix, input logic ue);
    @(negedge clk);
    evalValid = 1'b1; respCode = r; rxBytes = rx; descActive = a;
    descStatus = st; descBytes = b; cMask = 8'h1C; cProgMask = pm;
    uframeIdx = ix; uframeEnd = ue;
    @(negedge clk);
    evalValid = 1'b0; uframeEnd = 1'b0;
  endtask

  task automatic expectOut(input string req, input logic a, input logic [1:0] st,
                           input logic [9:0] b, input logic [7:0] pm,
                           input logic rq, input logic ab);
    check({req, " valid"},  int'(updValid),    1);
    check({req, " active"}, int'(updActive),   int'(a));
    check({req, " status"}, int'(updStatus),   int'(st));
    check({req, " bytes"},  int'(updBytes),    int'(b));
    check({req, " prog"},   int'(updProgMask), int'(pm));
    check({req, " retry"},  int'(retryReq),    int'(rq));
    check({req, " abort"},  int'(uframeAbort), int'(ab));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: reset state
    check("R14 valid", int'(updValid), 0);
    check("R14 retry", int'(retryReq), 0);
    check("R14 abort", int'(uframeAbort), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].resp, VEC[i].rx, VEC[i].act, VEC[i].st, VEC[i].bytes,
            VEC[i].prog, VEC[i].idx, 1'b0);
      expectOut($sformatf("vec%0d", i), VEC[i].eAct, VEC[i].eSt, VEC[i].eBytes,
                VEC[i].eProg, 1'b0, 1'b0);
      check("R1 pulse", int'(updValid), 1);
      @(negedge clk);
      check("R1 pulse ends", int'(updValid), 0);
    end

    // R2, R3: three errors in a row
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0);
    expectOut("R2 first error", 1'b1, 2'b01, 10'd100, 8'h00, 1'b1, 1'b0);
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0);
    expectOut("R2 second error", 1'b1, 2'b01, 10'd100, 8'h00, 1'b1, 1'b0);
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0);
    expectOut("R3 exhausted", 1'b0, 2'b01, 10'd100, 8'h00, 1'b0, 1'b1);

    // R5: a NYET between errors resets the count
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0);
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0);
    apply(3'd3, 10'd0, 1'b1, 2'b00, 10'd100, 8'h00, 3'd2, 1'b0);
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h04, 3'd3, 1'b0);
    expectOut("R5 count cleared", 1'b1, 2'b01, 10'd100, 8'h04, 1'b1, 1'b0);

    // R4: error at microframe end (count is one here, retries remain)
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h04, 3'd3, 1'b1);
    expectOut("R4 uframe end", 1'b0, 2'b01, 10'd100, 8'h04, 1'b0, 1'b1);

    // R3: after an abort the count restarts
    apply(3'd4, 10'd0, 1'b1, 2'b00, 10'd100, 8'h04, 3'd3, 1'b0);
    expectOut("R3 count restarts", 1'b1, 2'b01, 10'd100, 8'h04, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule